// File: doc/BRIEF.md
# Two-Level Grouped Carry Lookahead Adder

This block is a purely combinational unsigned adder. Two operands of equal width and a carry input produce a sum of the same width and a carry output. The operand bits are divided into equal groups. Inside a group, every carry is written as a flat sum of products of the bit generate and bit propagate terms and the carry entering the group. Each group also reports one group generate term and one group propagate term.

A second lookahead stage uses the group terms to form the carry entering every group directly from the block carry input. No carry travels bit by bit across the word. In the default size there are three groups of three bits, so the group width and the group count are equal. The block has no clock and no state. It is placed wherever a fast single-cycle add is needed.

Top module: `cla_grouped_adder`

## Requirements
- R1: For every value of `a`, `b` and `cin`, `sum` equals the low WIDTH bits of a + b + cin, where WIDTH = GROUP_W * NUM_GROUPS (default 9).
- R2: For every value of `a`, `b` and `cin`, `cout` equals bit WIDTH of a + b + cin.
- R3: When every bit position propagates (a XOR b is all ones), `cin` passes through every group. With cin = 1 the result is sum = 0 and cout = 1. With cin = 0 the result is sum = all ones and cout = 0.
- R4: A carry made in a lower group reaches the next group. The carry into group k+1 is the group-k generate term, or the group-k propagate term and the carry into group k. Examples: a = 0x007 with b = 0x001 gives 0x008, and a = 0x03F with b = 0x001 gives 0x040.
- R5: A group raises its generate term exactly when it sends out a carry without needing one from below. A group's generate and propagate terms are never both high. With a = b = 0x100 the top group generates, so cout = 1 and sum = 0.
- R6: With a = 0, b = 0 and cin = 0, the outputs are sum = 0 and cout = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, unsigned |
| b | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| cout | output | 1 | Carry out of the top group |

## Verification
The default nine-bit size is swept over all 2^19 combinations of both operands and the carry input, so every pattern of generate, propagate and kill inside each group is covered. A few directed patterns come first. A full propagate word with both carry-in values shows whether `cin` really reaches the top. Low-group carries into the next group show whether the group boundaries are correct. A top-group generate shows the carry-out path, and all-zero inputs give a quiet baseline. Internal group terms are compared against the group carries by the bound checker.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int DEF_GROUP_W    = 3;
  localparam int DEF_NUM_GROUPS = 3;

  typedef struct packed {
    logic gen;
    logic prop;
  } grp_pg_t;

  // per-bit generate: both operand bits high
  function automatic logic bit_gen(input logic x, input logic y);
    return x & y;
  endfunction

  // per-bit propagate: exactly one operand bit high (also the half sum)
  function automatic logic bit_prop(input logic x, input logic y);
    return x ^ y;
  endfunction
endpackage

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int GROUP_W = DEF_GROUP_W
) (
  input  logic [GROUP_W-1:0] gen,
  input  logic [GROUP_W-1:0] prop,
  input  logic               c_in,
  output logic [GROUP_W-1:0] c_bit,
  output grp_pg_t            grp
);
  // carry into bit i, sum of products over lower bits of this group
  always_comb begin
    for (int i = 0; i < GROUP_W; i++) begin
      logic acc;
      logic run;
      acc = 1'b0;
      run = 1'b1;
      for (int j = i - 1; j >= 0; j--) begin
        acc = acc | (run & gen[j]);
        run = run & prop[j];
      end
      c_bit[i] = acc | (run & c_in);
    end
  end

  // group generate and propagate, independent of the incoming carry
  always_comb begin
    logic acc;
    logic run;
    acc = 1'b0;
    run = 1'b1;
    for (int j = GROUP_W - 1; j >= 0; j--) begin
      acc = acc | (run & gen[j]);
      run = run & prop[j];
    end
    grp.gen  = acc;
    grp.prop = run;
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int NUM_GROUPS = cla_pkg::DEF_NUM_GROUPS
) (
  input  logic [NUM_GROUPS-1:0] g_gen,
  input  logic [NUM_GROUPS-1:0] g_prop,
  input  logic                  c_in,
  output logic [NUM_GROUPS:0]   g_carry
);
  // carry into group k, expanded from the block carry input
  always_comb begin
    for (int k = 0; k <= NUM_GROUPS; k++) begin
      logic acc;
      logic run;
      acc = 1'b0;
      run = 1'b1;
      for (int j = k - 1; j >= 0; j--) begin
        acc = acc | (run & g_gen[j]);
        run = run & g_prop[j];
      end
      g_carry[k] = acc | (run & c_in);
    end
  end
endmodule

// File: rtl/cla_grouped_adder.sv
module cla_grouped_adder
  import cla_pkg::*;
#(
  parameter int GROUP_W    = DEF_GROUP_W,
  parameter int NUM_GROUPS = DEF_NUM_GROUPS,
  localparam int WIDTH     = GROUP_W * NUM_GROUPS
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH-1:0]      bit_g;
  logic [WIDTH-1:0]      bit_p;
  logic [WIDTH-1:0]      bit_c;
  logic [NUM_GROUPS-1:0] grp_gen;
  logic [NUM_GROUPS-1:0] grp_prop;
  logic [NUM_GROUPS:0]   grp_carry;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      bit_g[i] = bit_gen(a[i], b[i]);
      bit_p[i] = bit_prop(a[i], b[i]);
    end
  end

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
    grp_pg_t pg;
    cla_group #(.GROUP_W(GROUP_W)) u_group (
      .gen   (bit_g[k*GROUP_W +: GROUP_W]),
      .prop  (bit_p[k*GROUP_W +: GROUP_W]),
      .c_in  (grp_carry[k]),
      .c_bit (bit_c[k*GROUP_W +: GROUP_W]),
      .grp   (pg)
    );
    assign grp_gen[k]  = pg.gen;
    assign grp_prop[k] = pg.prop;
  end

  cla_lookahead #(.NUM_GROUPS(NUM_GROUPS)) u_lookahead (
    .g_gen   (grp_gen),
    .g_prop  (grp_prop),
    .c_in    (cin),
    .g_carry (grp_carry)
  );

  assign sum  = bit_p ^ bit_c;
  assign cout = grp_carry[NUM_GROUPS];
endmodule

// File: rtl/cla_grouped_adder_chk.sv
module cla_grouped_adder_chk #(
  parameter int GROUP_W    = 3,
  parameter int NUM_GROUPS = 3,
  localparam int WIDTH     = GROUP_W * NUM_GROUPS
) (
  input logic [WIDTH-1:0]      a,
  input logic [WIDTH-1:0]      b,
  input logic                  cin,
  input logic [WIDTH-1:0]      sum,
  input logic                  cout,
  input logic [NUM_GROUPS-1:0] grp_gen,
  input logic [NUM_GROUPS-1:0] grp_prop,
  input logic [NUM_GROUPS:0]   grp_carry
);
  logic [WIDTH:0] total;
  assign total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    AST_SUM_MATCH: assert (sum == total[WIDTH-1:0]); // R1
    AST_COUT_MATCH: assert (cout == total[WIDTH]); // R2
    AST_FULL_PROP: assert (!(&(a ^ b)) || (cout == cin)); // R3
    for (int k = 0; k < NUM_GROUPS; k++) begin
      AST_GRP_CARRY: assert (grp_carry[k+1] == (grp_gen[k] | (grp_prop[k] & grp_carry[k]))); // R4
      AST_GRP_GP_EXCL: assert (!(grp_gen[k] && grp_prop[k])); // R5
    end
  end
endmodule

bind cla_grouped_adder cla_grouped_adder_chk #(
  .GROUP_W    (GROUP_W),
  .NUM_GROUPS (NUM_GROUPS)
) u_chk (
  .a         (a),
  .b         (b),
  .cin       (cin),
  .sum       (sum),
  .cout      (cout),
  .grp_gen   (grp_gen),
  .grp_prop  (grp_prop),
  .grp_carry (grp_carry)
);

// File: tb/cla_grouped_adder_tb.sv
`timescale 1ns/1ps
module cla_grouped_adder_tb;
  localparam int GW = 3;
  localparam int NG = 3;
  localparam int W  = GW * NG;

  logic         clk = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  cla_grouped_adder #(.GROUP_W(GW), .NUM_GROUPS(NG)) u_dut (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%0b got=%h exp=%h", req, a, b, cin, got, exp);
    end
  endtask

  // drive between clock edges, settle half a ns, then sample
  task automatic apply(input logic [W-1:0] xa, input logic [W-1:0] xb, input logic xc);
    a = xa; b = xb; cin = xc;
    #0.5;
  endtask

  initial begin
    #0.25;
    // R6: all-zero inputs
    apply('0, '0, 1'b0);
    check("R6", {cout, sum}, '0);
    // R3: full propagate word, both carry-in values
    apply(9'h0AA, 9'h155, 1'b1);
    check("R3", {cout, sum}, {1'b1, 9'h000});
    #0.5;
    apply(9'h0AA, 9'h155, 1'b0);
    check("R3", {cout, sum}, {1'b0, 9'h1FF});
    #0.5;
    apply(9'h1FF, 9'h000, 1'b1);
    check("R3", {cout, sum}, {1'b1, 9'h000});
    #0.5;
    // R4: carries leaving group 0 and group 1
    apply(9'h007, 9'h001, 1'b0);
    check("R4", {cout, sum}, {1'b0, 9'h008});
    #0.5;
    apply(9'h03F, 9'h001, 1'b0);
    check("R4", {cout, sum}, {1'b0, 9'h040});
    #0.5;
    apply(9'h038, 9'h008, 1'b0);
    check("R4", {cout, sum}, {1'b0, 9'h040});
    #0.5;
    // R5: top group generates on its own
    apply(9'h100, 9'h100, 1'b0);
    check("R5", {cout, sum}, {1'b1, 9'h000});
    #0.5;
    apply(9'h1C0, 9'h040, 1'b0);
    check("R5", {cout, sum}, {1'b1, 9'h000});
    #0.5;
    // R1 and R2: exhaustive sweep against arithmetic addition
    for (int v = 0; v < (1 << (2*W + 1)); v++) begin
      logic [W:0] exp;
      exp = {1'b0, v[W-1:0]} + {1'b0, v[2*W-1:W]} + {{W{1'b0}}, v[2*W]};
      apply(v[W-1:0], v[2*W-1:W], v[2*W]);
      if ({cout, sum} !== exp) begin
        check(cout !== exp[W] ? "R2" : "R1", {cout, sum}, exp);
      end else begin
        n_run++;
      end
      #0.5;
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #700000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired, got=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule